// File: doc/BRIEF.md
# External Interrupt Controller with Priority Status

This block gathers sixty-four external interrupt lines and reduces them to one cascade request plus a readable source number. Each line is first synchronised to the block clock and then judged by its own sense rule. Most lines are treated as active-high levels. Lines 47 to 50 may also be set to latch a rising or a falling edge, or to act on a low level. A line takes part in selection only when its two enable bits are both set and detection is enabled for the whole block.

Among the lines that qualify, the one with the largest 8-bit priority wins. On a tie the lower line number wins. Its number is shown in the top byte of the status word. The value 63 in that byte means that no line is asserting a request. The single cascade output is a level. It follows the status byte, gated by the global detection enable and by a separate output enable.

Software reaches every setting over a 32-bit, word-addressed read/write port. Read data appears on the clock edge after the read request. Each line has two configuration words. Latched edges are removed by writing a clear command that carries the line's low four bits.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset the status word at 0x144 reads 0x3F000000, the cascade output is low, and the words at 0x004, 0x084 and every configuration word read 0.
- R2: Word A of line n sits at 0x200+8n and word B at 0x204+8n. Word A reads back its bits 29:28 and 25:24 as written, and word B reads back bits 7:0; every other bit reads 0.
- R3: A line can be selected only when bits 29:28 of its word A are both 1; the value 2'b01 leaves it out.
- R4: While bit 0 of the word at 0x004 is 0, the status byte is 63. An edge that occurs in that time is not latched.
- R5: Lines other than 47 to 50 act as active-high levels, whatever is written to their sense field (word A bits 25:24). On lines 47 to 50, sense code 0 selects an active-low level and code 1 an active-high level.
- R6: On lines 47 to 50, sense code 3 latches a rising edge and code 2 a falling edge. The latch holds after the input returns, and the edge that was not selected latches nothing.
- R7: Writing a word to 0x0C0 with bit 8 set clears the latch of the edge line whose number has bits 3:0 equal to the word's bits 3:0. A word with bit 8 clear, or with another index, leaves every latch unchanged.
- R8: When an edge reaches the detector in the same cycle as the clear command for that line, the latch stays set.
- R9: Among the qualifying lines, the one with the largest word B bits 7:0 is reported; on equal values the lower line number is reported.
- R10: The status word at 0x144 carries the reported line number in bits 31:24, or 63 when no line qualifies; bits 23:0 read 0.
- R11: The cascade output is high exactly when bit 0 at 0x004 and bit 0 at 0x444 are both 1 and the status byte is not 63.
- R12: The word at 0x084 holds all 32 written bits for readback and has no effect on selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A register access is presented this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| src_in | input | 64 | External interrupt lines, asynchronous |
| cascade_irq | output | 1 | Level request towards the next interrupt stage |

## Verification
The delicate overlap is between a new edge arriving at the detector and a software clear for the same line in a single cycle. The bench drives the input change two clock edges ahead of the clear write, so that both reach the latch at the same edge. It then reads the status word and expects the line still reported. A second clear, sent with the input held steady, must then drop the status to 63. This separates a design in which the set takes precedence from one in which the clear does.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int PRI_W  = 8;
    localparam int ID_FIELD_W = 8;
    localparam int ID_SHIFT   = 24;

    localparam int EDGE_LO = 47;
    localparam int EDGE_HI = 50;

    localparam logic [ADDR_W-1:0] OFF_DETEN   = 12'h004;
    localparam logic [ADDR_W-1:0] OFF_LVLMSK  = 12'h084;
    localparam logic [ADDR_W-1:0] OFF_EDGECLR = 12'h0C0;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 12'h144;
    localparam logic [ADDR_W-1:0] OFF_PKTEN   = 12'h444;
    localparam logic [ADDR_W-1:0] CFG_BASE    = 12'h200;

    localparam int CLR_CMD_BIT = 8;
    localparam int CLR_IDX_W   = 4;

    typedef enum logic [1:0] {
        SENSE_LVL_LO = 2'd0,
        SENSE_LVL_HI = 2'd1,
        SENSE_FALL   = 2'd2,
        SENSE_RISE   = 2'd3
    } sense_e;

    typedef struct packed {
        logic [1:0]       en;
        sense_e           sense;
        logic [PRI_W-1:0] pri;
    } src_cfg_t;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] pack_word_a(src_cfg_t c);
        return {2'b00, c.en, 2'b00, c.sense, 24'h000000};
    endfunction

    function automatic logic [DATA_W-1:0] pack_word_b(src_cfg_t c);
        return {{(DATA_W-PRI_W){1'b0}}, c.pri};
    endfunction

    function automatic logic src_enabled(src_cfg_t c);
        return c.en == 2'b11;
    endfunction

endpackage

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  bus_req_t                   req,
    input  logic [$clog2(NUM_SRC)-1:0] status_id,
    output src_cfg_t [NUM_SRC-1:0]     cfg,
    output logic                       det_en,
    output logic                       pkt_en,
    output logic                       clr_valid,
    output logic [CLR_IDX_W-1:0]       clr_idx,
    output logic [DATA_W-1:0]          rd_data
);
    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int SPAN_W = 3 + SRC_W;

    logic [ADDR_W-1:0] waddr;
    logic              cfg_hit;
    logic [SRC_W-1:0]  cfg_idx;
    logic              cfg_wordb;
    logic              wr;
    logic              rd;
    logic [DATA_W-1:0] lvlmsk_q;
    logic [DATA_W-1:0] rd_value;
    src_cfg_t          cfg_q [NUM_SRC];
    logic              unused_bits;

    assign waddr     = {req.addr[ADDR_W-1:2], 2'b00};
    assign cfg_hit   = (waddr[ADDR_W-1:SPAN_W] == CFG_BASE[ADDR_W-1:SPAN_W]);
    assign cfg_idx   = waddr[SPAN_W-1:3];
    assign cfg_wordb = waddr[2];
    assign wr        = req.valid && req.write;
    assign rd        = req.valid && !req.write;
    assign unused_bits = ^req.wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) cfg_q[i] <= '0;
        end else if (wr && cfg_hit) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (cfg_idx == SRC_W'(i)) begin
                    if (cfg_wordb) begin
                        cfg_q[i].pri <= req.wdata[PRI_W-1:0];
                    end else begin
                        cfg_q[i].en    <= req.wdata[29:28];
                        cfg_q[i].sense <= sense_e'(req.wdata[25:24]);
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cfg_out
        assign cfg[g] = cfg_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            det_en   <= 1'b0;
            pkt_en   <= 1'b0;
            lvlmsk_q <= '0;
        end else if (wr) begin
            if (waddr == OFF_DETEN)  det_en   <= req.wdata[0];
            if (waddr == OFF_PKTEN)  pkt_en   <= req.wdata[0];
            if (waddr == OFF_LVLMSK) lvlmsk_q <= req.wdata;
        end
    end

    assign clr_valid = wr && (waddr == OFF_EDGECLR) && req.wdata[CLR_CMD_BIT];
    assign clr_idx   = req.wdata[CLR_IDX_W-1:0];

    always_comb begin
        rd_value = '0;
        if (cfg_hit) begin
            rd_value = cfg_wordb ? pack_word_b(cfg_q[cfg_idx])
                                 : pack_word_a(cfg_q[cfg_idx]);
        end else if (waddr == OFF_DETEN) begin
            rd_value = {{(DATA_W-1){1'b0}}, det_en};
        end else if (waddr == OFF_PKTEN) begin
            rd_value = {{(DATA_W-1){1'b0}}, pkt_en};
        end else if (waddr == OFF_LVLMSK) begin
            rd_value = lvlmsk_q;
        end else if (waddr == OFF_STATUS) begin
            rd_value = {ID_FIELD_W'(status_id), {ID_SHIFT{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd) begin
            rd_data <= rd_value;
        end
    end

endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_SRC-1:0]     src_in,
    input  src_cfg_t [NUM_SRC-1:0] cfg,
    input  logic                   det_en,
    input  logic                   clr_valid,
    input  logic [CLR_IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0]     pend,
    output logic [NUM_SRC-1:0]     edge_seen,
    output logic [NUM_SRC-1:0]     clr_match,
    output logic [NUM_SRC-1:0]     latch_q
);
    logic unused_cfg;
    assign unused_cfg = ^cfg;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [SYNC_STAGES:0] shreg;
        logic cur;
        logic prev;
        logic cond;

        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[SYNC_STAGES-1:0], src_in[g]};
        end

        assign cur  = shreg[SYNC_STAGES-1];
        assign prev = shreg[SYNC_STAGES];

        if (g >= EDGE_LO && g <= EDGE_HI) begin : g_edge
            localparam logic [CLR_IDX_W-1:0] LOW_ID = CLR_IDX_W'(g);
            logic latch_r;
            logic hit;
            logic kill;

            assign hit = det_en &&
                         (((cfg[g].sense == SENSE_RISE) && cur && !prev) ||
                          ((cfg[g].sense == SENSE_FALL) && !cur && prev));
            assign kill = clr_valid && (clr_idx == LOW_ID);

            always_ff @(posedge clk) begin
                if (rst) latch_r <= 1'b0;
                else     latch_r <= hit || (latch_r && !kill);
            end

            always_comb begin
                case (cfg[g].sense)
                    SENSE_LVL_LO: cond = !cur;
                    SENSE_LVL_HI: cond = cur;
                    default:      cond = latch_r;
                endcase
            end

            assign edge_seen[g] = hit;
            assign clr_match[g] = kill;
            assign latch_q[g]   = latch_r;
        end else begin : g_level
            assign cond         = cur;
            assign edge_seen[g] = 1'b0;
            assign clr_match[g] = 1'b0;
            assign latch_q[g]   = 1'b0;
        end

        assign pend[g] = det_en && src_enabled(cfg[g]) && cond;
    end

endmodule

// File: rtl/extirq_select.sv
module extirq_select
    import extirq_pkg::*;
#(
    parameter int NUM_SRC = 64
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         pend,
    input  src_cfg_t [NUM_SRC-1:0]     cfg,
    output logic [$clog2(NUM_SRC)-1:0] status_id
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam logic [SRC_W-1:0] NONE_ID = SRC_W'(NUM_SRC - 1);

    logic             found;
    logic [PRI_W-1:0] best_pri;
    logic [SRC_W-1:0] best_id;
    logic             unused_cfg;

    assign unused_cfg = ^cfg;

    always_comb begin
        found    = 1'b0;
        best_pri = '0;
        best_id  = NONE_ID;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend[i] && (!found || cfg[i].pri >= best_pri)) begin
                found    = 1'b1;
                best_pri = cfg[i].pri;
                best_id  = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_id <= NONE_ID;
        else     status_id <= best_id;
    end

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_SRC     = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [11:0]        req_addr,
    input  logic [31:0]        req_wdata,
    output logic [31:0]        rd_data,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               cascade_irq
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam logic [SRC_W-1:0] NONE_ID = SRC_W'(NUM_SRC - 1);

    bus_req_t               req;
    src_cfg_t [NUM_SRC-1:0] cfg;
    logic                   det_en;
    logic                   pkt_en;
    logic                   clr_valid;
    logic [CLR_IDX_W-1:0]   clr_idx;
    logic [NUM_SRC-1:0]     pend;
    logic [NUM_SRC-1:0]     edge_seen;
    logic [NUM_SRC-1:0]     clr_match;
    logic [NUM_SRC-1:0]     latch_q;
    logic [SRC_W-1:0]       status_id;

    assign req.valid = req_valid;
    assign req.write = req_write;
    assign req.addr  = req_addr;
    assign req.wdata = req_wdata;

    extirq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .status_id (status_id),
        .cfg       (cfg),
        .det_en    (det_en),
        .pkt_en    (pkt_en),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .rd_data   (rd_data)
    );

    extirq_detect #(.NUM_SRC(NUM_SRC), .SYNC_STAGES(SYNC_STAGES)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .src_in    (src_in),
        .cfg       (cfg),
        .det_en    (det_en),
        .clr_valid (clr_valid),
        .clr_idx   (clr_idx),
        .pend      (pend),
        .edge_seen (edge_seen),
        .clr_match (clr_match),
        .latch_q   (latch_q)
    );

    extirq_select #(.NUM_SRC(NUM_SRC)) u_select (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .cfg       (cfg),
        .status_id (status_id)
    );

    assign cascade_irq = det_en && pkt_en && (status_id != NONE_ID);

endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
    parameter int NUM_SRC = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       det_en,
    input logic                       cascade_irq,
    input logic [NUM_SRC-1:0]         pend,
    input logic [NUM_SRC-1:0]         edge_seen,
    input logic [NUM_SRC-1:0]         clr_match,
    input logic [NUM_SRC-1:0]         latch_q,
    input logic [$clog2(NUM_SRC)-1:0] status_id
);
    localparam int SRC_W = $clog2(NUM_SRC);
    localparam logic [SRC_W-1:0] NONE_ID = SRC_W'(NUM_SRC - 1);

    logic [NUM_SRC-1:0] pend_d;

    always_ff @(posedge clk) begin
        if (rst) pend_d <= '0;
        else     pend_d <= pend;
    end

    p_quiet_without_det_r4: assert property (@(posedge clk) disable iff (rst)
        !det_en |=> (status_id == NONE_ID));

    p_winner_was_pending_r9: assert property (@(posedge clk) disable iff (rst)
        (status_id != NONE_ID) |-> pend_d[status_id]);

    p_idle_code_r10: assert property (@(posedge clk) disable iff (rst)
        (pend_d == '0) |-> (status_id == NONE_ID));

    p_cascade_needs_request_r11: assert property (@(posedge clk) disable iff (rst)
        cascade_irq |-> (pend_d != '0));

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_latch_chk
        p_set_beats_clear_r8: assert property (@(posedge clk) disable iff (rst)
            (edge_seen[g] && clr_match[g]) |=> latch_q[g]);

        p_clear_drops_latch_r7: assert property (@(posedge clk) disable iff (rst)
            (clr_match[g] && !edge_seen[g]) |=> !latch_q[g]);
    end

endmodule

bind extirq_ctrl extirq_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .det_en      (det_en),
    .cascade_irq (cascade_irq),
    .pend        (pend),
    .edge_seen   (edge_seen),
    .clr_match   (clr_match),
    .latch_q     (latch_q),
    .status_id   (status_id)
);

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic [63:0] src_in = '0;
    logic        cascade_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    extirq_ctrl u_extirq_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rd_data     (rd_data),
        .src_in      (src_in),
        .cascade_irq (cascade_irq)
    );

    localparam int NVEC = 9;
    localparam logic [63:0] TV_IN [NVEC] = '{
        64'h0000_0000_0000_0008,
        64'h0000_0000_0000_0028,
        64'h0000_0000_0010_0020,
        64'h0000_0100_0000_0000,
        64'h5000_0000_0000_0000,
        64'h5000_0100_0010_0028,
        64'h0000_0000_0000_0080,
        64'h0000_0000_0000_0000,
        64'h0000_0100_0000_0020
    };
    localparam logic [7:0] TV_EXP [NVEC] = '{
        8'd3, 8'd3, 8'd20, 8'd40, 8'd60, 8'd60, 8'd63, 8'd63, 8'd5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    task automatic expect_status(input string req, input logic [7:0] id);
        logic [31:0] v;
        settle();
        rd_reg(12'h144, v);
        check(req, v, {id, 24'h0});
    endtask

    task automatic set_src(input int n, input logic [31:0] wa, input logic [31:0] wb);
        wr_reg(12'(12'h200 + 8 * n), wa);
        wr_reg(12'(12'h204 + 8 * n), wb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd_reg(12'h144, v); check("R1 status", v, 32'h3F00_0000);
        check("R1 cascade", {31'h0, cascade_irq}, 32'h0);
        rd_reg(12'h004, v); check("R1 detect enable", v, 32'h0);
        rd_reg(12'h084, v); check("R1 level mask", v, 32'h0);
        rd_reg(12'h250, v); check("R1 cfg word A", v, 32'h0);

        // R2 readback of only the kept fields
        set_src(12, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd_reg(12'h260, v); check("R2 word A", v, 32'h3300_0000);
        rd_reg(12'h264, v); check("R2 word B", v, 32'h0000_00FF);
        set_src(12, 32'h0, 32'h0);

        // table sources, level high enabled
        set_src(3,  32'h3100_0000, 32'd10);
        set_src(5,  32'h3100_0000, 32'd10);
        set_src(20, 32'h3100_0000, 32'd200);
        set_src(40, 32'h3100_0000, 32'd0);
        set_src(60, 32'h3100_0000, 32'd255);
        set_src(62, 32'h3100_0000, 32'd255);
        set_src(48, 32'h3300_0000, 32'd50);
        wr_reg(12'h444, 32'h1);

        // R4 detection disabled
        @(negedge clk) src_in[3] = 1'b1;
        expect_status("R4 level while disabled", 8'd63);
        check("R4 cascade while disabled", {31'h0, cascade_irq}, 32'h0);
        @(negedge clk) src_in[48] = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) begin src_in[48] = 1'b0; src_in[3] = 1'b0; end
        repeat (4) @(posedge clk);
        wr_reg(12'h004, 32'h1);
        expect_status("R4 edge not latched while disabled", 8'd63);

        // R9 R3 R10 R11 table walk
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk) src_in = TV_IN[i];
            expect_status($sformatf("R9 vector %0d", i), TV_EXP[i]);
            check($sformatf("R11 cascade vector %0d", i), {31'h0, cascade_irq},
                  {31'h0, TV_EXP[i] != 8'd63});
        end
        @(negedge clk) src_in = '0;
        expect_status("R10 idle", 8'd63);

        // R6 rising edge latch on 48
        @(negedge clk) src_in[48] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) src_in[48] = 1'b0;
        expect_status("R6 rising latched", 8'd48);
        // R7 non-commands and other index
        wr_reg(12'h0C0, 32'h0000_0000);
        expect_status("R7 bit8 clear ignored", 8'd48);
        wr_reg(12'h0C0, 32'h0000_0101);
        expect_status("R7 other index ignored", 8'd48);
        wr_reg(12'h0C0, 32'h0000_0100);
        expect_status("R7 clear of 48", 8'd63);

        // R6 falling edge on 47
        set_src(47, 32'h3200_0000, 32'd60);
        @(negedge clk) src_in[47] = 1'b1;
        expect_status("R6 rising ignored in falling mode", 8'd63);
        @(negedge clk) src_in[47] = 1'b0;
        expect_status("R6 falling latched", 8'd47);
        wr_reg(12'h0C0, 32'h0000_010F);
        expect_status("R7 clear of 47", 8'd63);

        // R8 edge and clear in the same cycle
        @(negedge clk) src_in[48] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        wr_reg(12'h0C0, 32'h0000_0100);
        expect_status("R8 set wins over clear", 8'd48);
        wr_reg(12'h0C0, 32'h0000_0100);
        expect_status("R8 later clear drops latch", 8'd63);
        @(negedge clk) src_in[48] = 1'b0;

        // R5 sense field on a level-only line and on line 49
        set_src(10, 32'h3000_0000, 32'd1);
        expect_status("R5 code 0 outside window is not active low", 8'd63);
        @(negedge clk) src_in[10] = 1'b1;
        expect_status("R5 code 0 outside window acts high", 8'd10);
        @(negedge clk) src_in[10] = 1'b0;
        set_src(49, 32'h3000_0000, 32'd2);
        expect_status("R5 level low on 49", 8'd49);
        @(negedge clk) src_in[49] = 1'b1;
        expect_status("R5 level low released", 8'd63);
        set_src(49, 32'h0, 32'h0);
        @(negedge clk) src_in[49] = 1'b0;
        expect_status("R3 disabled 49 with low input", 8'd63);

        // R3 only one enable bit
        wr_reg(12'h218, 32'h1100_0000);
        @(negedge clk) src_in[3] = 1'b1;
        expect_status("R3 single enable bit", 8'd63);
        wr_reg(12'h218, 32'h3100_0000);
        expect_status("R3 both enable bits", 8'd3);

        // R11 output gating
        check("R11 cascade on", {31'h0, cascade_irq}, 32'h1);
        wr_reg(12'h444, 32'h0);
        expect_status("R11 status kept without output enable", 8'd3);
        check("R11 cascade off", {31'h0, cascade_irq}, 32'h0);
        wr_reg(12'h444, 32'h1);
        settle();
        check("R11 cascade back", {31'h0, cascade_irq}, 32'h1);
        wr_reg(12'h004, 32'h0);
        expect_status("R4 detect cleared", 8'd63);
        check("R11 cascade with detect cleared", {31'h0, cascade_irq}, 32'h0);
        wr_reg(12'h004, 32'h1);

        // R12 level mask storage only
        wr_reg(12'h084, 32'hFFFF_FFFF);
        rd_reg(12'h084, v); check("R12 mask readback", v, 32'hFFFF_FFFF);
        expect_status("R12 mask has no effect", 8'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule